// File: doc/BRIEF.md
# Alternating Capture-Unit Controller

This block runs two waveform-capture units that watch the same photomultiplier signals and take turns. A pulse from the high-threshold discriminator starts a capture on the unit that is currently armed. The controller then arms the other unit, so a second pulse can be taken while the first unit is still digitizing and reading out. A trigger is lost only when a pulse arrives while both units are still busy. The controller counts lost triggers in a saturating counter.

The capture units are modelled as simple handshakes. A start pulse begins a capture. The unit then offers its samples with a valid signal, one sample per cycle, and the controller grants one unit at a time. A 2:1 selector passes the granted unit's samples into a registered output stage. Each output sample carries the unit that captured it, a record sequence number taken when the trigger was accepted, and a flag on the final sample of the record. Records leave in the order in which their triggers were accepted. The second unit's readout does not begin until every sample of the earlier record has been passed on.

The sampling itself and its timing are inside the capture units. This logic runs on the board clock.

Top module: `dual_capture_pingpong`

## Requirements
- R1: After reset, `busy_o` is 2'b00, `armed_o` is 0 (unit 0 armed), `lost_cnt_o` is 0, `out_valid_o` is 0 and `cap_ready_o` is 2'b00.
- R2: A trigger sampled at a clock edge while the armed unit is free raises that unit's bit in `cap_start_o` (bit 0 = unit 0, bit 1 = unit 1) for exactly the following cycle. At the same edge it sets that unit's `busy_o` bit and moves `armed_o` to the other unit.
- R3: A trigger is accepted whenever at least one unit is free. If the armed unit is busy and the other unit is free, the trigger starts the other unit. The newly armed unit is always the one not just started.
- R4: A trigger that arrives while both units are busy starts no unit. It raises `lost_cnt_o` by one at that edge.
- R5: `lost_cnt_o` saturates at its all-ones value and holds there on further lost triggers.
- R6: A unit's `busy_o` bit stays set from its start until the edge at which its last sample (sample index SAMPLES-1) is taken, and clears at that edge.
- R7: Only the unit at the head of the trigger order is granted (`cap_ready_o` has at most one bit set). Samples offered by the other unit are not forwarded and do not appear at the output.
- R8: Every sample taken from a unit appears on `out_data_o` one cycle later, with `out_valid_o` high. The sample is tagged with `out_unit_o` set to the capturing unit and `out_seq_o` set to the record number. Record numbers count accepted triggers from 0, modulo 2^SEQ_W.
- R9: `out_last_o` is high on exactly the final sample (index SAMPLES-1) of each record. Records appear at the output in the order in which their triggers were accepted.
- R10: At most one bit of `cap_start_o` is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | High-threshold discriminator pulse, one cycle per hit |
| cap_start_o | output | 2 | One-cycle start pulse per capture unit |
| cap_valid_i | input | 2 | Sample offered by each unit |
| cap_data_i | input | 2*SAMPLE_W | Sample of unit 0 in the low half, unit 1 in the high half |
| cap_ready_o | output | 2 | Grant to take one sample from a unit |
| busy_o | output | 2 | Unit capturing or draining |
| armed_o | output | 1 | Unit that takes the next trigger |
| lost_cnt_o | output | LOST_W | Saturating count of lost triggers |
| out_valid_o | output | 1 | Output sample present |
| out_data_o | output | SAMPLE_W | Output sample value |
| out_unit_o | output | 1 | Unit that captured the sample |
| out_seq_o | output | SEQ_W | Record number of the sample |
| out_last_o | output | 1 | Final sample of a record |

## Verification
The embedded properties assume several things about the inputs. The discriminator input is a clean pulse. A capture unit offers samples only after it has received a start and before it has delivered SAMPLES of them. A unit keeps its sample value steady until that sample is granted. The bench's capture-unit model follows these rules. It waits a fixed latency after each start, then presents an indexed pattern one sample at a time and advances only on a grant. It flags any start that reaches a unit already in a capture. Triggers are always driven as single-cycle pulses away from the clock edge. Lost triggers are fired only in windows where the bench has already seen both busy bits set.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic {
        UNIT_A = 1'b0,
        UNIT_B = 1'b1
    } unit_e;

    localparam int unsigned NUM_UNITS = 2;

endpackage

// File: rtl/pp_steer.sv
module pp_steer
    import pp_pkg::*;
#(
    parameter int unsigned LOST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [1:0]        done_i,
    output logic [1:0]        start_o,
    output logic [1:0]        busy_o,
    output unit_e             armed_o,
    output logic              accept_o,
    output unit_e             accept_unit_o,
    output logic [LOST_W-1:0] lost_o
);

    localparam logic [LOST_W-1:0] LOST_MAX = {LOST_W{1'b1}};

    typedef struct packed {
        logic [1:0]        busy;
        logic [1:0]        start;
        unit_e             armed;
        logic [LOST_W-1:0] lost;
    } steer_t;

    steer_t s_d, s_q;
    unit_e  other;
    unit_e  chosen;
    logic   armed_free;
    logic   other_free;
    logic   accept;

    always_comb begin
        s_d        = s_q;
        s_d.start  = 2'b00;
        other      = unit_e'(~s_q.armed);
        armed_free = !s_q.busy[s_q.armed];
        other_free = !s_q.busy[other];
        chosen     = armed_free ? s_q.armed : other;
        accept     = trig_i && (armed_free || other_free);
        if (accept) begin
            s_d.start[chosen] = 1'b1;
            s_d.armed         = unit_e'(~chosen);
        end else if (trig_i && (s_q.lost != LOST_MAX)) begin
            s_d.lost = s_q.lost + 1'b1;
        end
        s_d.busy = (s_q.busy & ~done_i) | s_d.start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{busy: 2'b00, start: 2'b00, armed: UNIT_A, lost: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign start_o       = s_q.start;
    assign busy_o        = s_q.busy;
    assign armed_o       = s_q.armed;
    assign lost_o        = s_q.lost;
    assign accept_o      = accept;
    assign accept_unit_o = chosen;

    // R4
    lost_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && busy_o == 2'b11 && lost_o != LOST_MAX) |=> (lost_o == $past(lost_o) + 1'b1));

    // R5
    lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_o == LOST_MAX) |=> (lost_o == LOST_MAX));

    // R10
    start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_o));

    // R2
    start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|start_o) |-> ((start_o & $past(busy_o)) == 2'b00));

    // R3
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && busy_o != 2'b11) |=> ($countones(start_o) == 1));

endmodule

// File: rtl/pp_order.sv
module pp_order
    import pp_pkg::*;
#(
    parameter int unsigned SEQ_W = 4,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  unit_e            push_unit_i,
    input  logic             pop_i,
    output logic             head_vld_o,
    output unit_e            head_unit_o,
    output logic [SEQ_W-1:0] head_seq_o
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL_CNT  = (AW + 1)'(DEPTH);

    typedef struct packed {
        unit_e            unit;
        logic [SEQ_W-1:0] seq;
    } rec_t;

    typedef struct packed {
        rec_t [DEPTH-1:0] mem;
        logic [AW-1:0]    wr;
        logic [AW-1:0]    rd;
        logic [AW:0]      cnt;
        logic [SEQ_W-1:0] seq;
    } order_t;

    order_t o_d, o_q;
    logic   do_pop;

    always_comb begin
        o_d    = o_q;
        do_pop = pop_i && (o_q.cnt != '0);
        if (do_pop) begin
            o_d.rd = (o_q.rd == LAST_SLOT) ? '0 : o_q.rd + 1'b1;
        end
        if (push_i) begin
            o_d.mem[o_q.wr] = '{unit: push_unit_i, seq: o_q.seq};
            o_d.wr          = (o_q.wr == LAST_SLOT) ? '0 : o_q.wr + 1'b1;
            o_d.seq         = o_q.seq + 1'b1;
        end
        case ({push_i, do_pop})
            2'b10:   o_d.cnt = o_q.cnt + 1'b1;
            2'b01:   o_d.cnt = o_q.cnt - 1'b1;
            default: o_d.cnt = o_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign head_vld_o  = (o_q.cnt != '0);
    assign head_unit_o = o_q.mem[o_q.rd].unit;
    assign head_seq_o  = o_q.mem[o_q.rd].seq;

    // R9
    order_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && (o_q.cnt == FULL_CNT) && !pop_i));

    // R6
    order_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> head_vld_o);

endmodule

// File: rtl/pp_drain.sv
module pp_drain
    import pp_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 10,
    parameter int unsigned SAMPLES  = 128,
    parameter int unsigned SEQ_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cap_valid_i,
    input  logic [2*SAMPLE_W-1:0] cap_data_i,
    input  logic                  head_vld_i,
    input  unit_e                 head_unit_i,
    input  logic [SEQ_W-1:0]      head_seq_i,
    output logic [1:0]            cap_ready_o,
    output logic                  pop_o,
    output logic [1:0]            done_o,
    output logic                  out_valid_o,
    output logic [SAMPLE_W-1:0]   out_data_o,
    output unit_e                 out_unit_o,
    output logic [SEQ_W-1:0]      out_seq_o,
    output logic                  out_last_o
);

    localparam int unsigned CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(SAMPLES - 1);

    typedef struct packed {
        logic [CW-1:0]       cnt;
        logic                ov;
        logic [SAMPLE_W-1:0] odata;
        unit_e               ounit;
        logic [SEQ_W-1:0]    oseq;
        logic                olast;
    } drain_t;

    drain_t d_d, d_q;
    logic [SAMPLE_W-1:0] lane [NUM_UNITS];
    logic [1:0]          grant;
    logic                take;
    logic                is_last;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_lane
        assign lane[u] = cap_data_i[u*SAMPLE_W +: SAMPLE_W];
    end

    always_comb begin
        d_d     = d_q;
        grant   = head_vld_i ? (2'b01 << head_unit_i) : 2'b00;
        take    = |(grant & cap_valid_i);
        is_last = (d_q.cnt == LAST_IDX);
        d_d.ov  = take;
        pop_o   = 1'b0;
        done_o  = 2'b00;
        if (take) begin
            d_d.odata = lane[head_unit_i];
            d_d.ounit = head_unit_i;
            d_d.oseq  = head_seq_i;
            d_d.olast = is_last;
            d_d.cnt   = is_last ? '0 : d_q.cnt + 1'b1;
            pop_o     = is_last;
            done_o    = is_last ? grant : 2'b00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '{cnt: '0, ov: 1'b0, odata: '0, ounit: UNIT_A, oseq: '0, olast: 1'b0};
        end else begin
            d_q <= d_d;
        end
    end

    assign cap_ready_o = grant;
    assign out_valid_o = d_q.ov;
    assign out_data_o  = d_q.odata;
    assign out_unit_o  = d_q.ounit;
    assign out_seq_o   = d_q.oseq;
    assign out_last_o  = d_q.olast;

    // R7
    ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cap_ready_o));

    // R9
    last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |=> (out_valid_o && out_last_o));

    // R8
    seq_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_last_o) |=> (!out_valid_o || out_seq_o == $past(out_seq_o)));

endmodule

// File: rtl/dual_capture_pingpong.sv
module dual_capture_pingpong
    import pp_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 10,
    parameter int unsigned SAMPLES  = 128,
    parameter int unsigned SEQ_W    = 4,
    parameter int unsigned LOST_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig_i,
    output logic [1:0]            cap_start_o,
    input  logic [1:0]            cap_valid_i,
    input  logic [2*SAMPLE_W-1:0] cap_data_i,
    output logic [1:0]            cap_ready_o,
    output logic [1:0]            busy_o,
    output logic                  armed_o,
    output logic [LOST_W-1:0]     lost_cnt_o,
    output logic                  out_valid_o,
    output logic [SAMPLE_W-1:0]   out_data_o,
    output logic                  out_unit_o,
    output logic [SEQ_W-1:0]      out_seq_o,
    output logic                  out_last_o
);

    logic             accept;
    unit_e            accept_unit;
    unit_e            armed;
    logic [1:0]       done;
    logic             pop;
    logic             head_vld;
    unit_e            head_unit;
    logic [SEQ_W-1:0] head_seq;
    unit_e            out_unit;

    pp_steer #(
        .LOST_W(LOST_W)
    ) steer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig_i),
        .done_i       (done),
        .start_o      (cap_start_o),
        .busy_o       (busy_o),
        .armed_o      (armed),
        .accept_o     (accept),
        .accept_unit_o(accept_unit),
        .lost_o       (lost_cnt_o)
    );

    pp_order #(
        .SEQ_W(SEQ_W),
        .DEPTH(NUM_UNITS)
    ) order_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (accept),
        .push_unit_i(accept_unit),
        .pop_i      (pop),
        .head_vld_o (head_vld),
        .head_unit_o(head_unit),
        .head_seq_o (head_seq)
    );

    pp_drain #(
        .SAMPLE_W(SAMPLE_W),
        .SAMPLES (SAMPLES),
        .SEQ_W   (SEQ_W)
    ) drain_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_valid_i(cap_valid_i),
        .cap_data_i (cap_data_i),
        .head_vld_i (head_vld),
        .head_unit_i(head_unit),
        .head_seq_i (head_seq),
        .cap_ready_o(cap_ready_o),
        .pop_o      (pop),
        .done_o     (done),
        .out_valid_o(out_valid_o),
        .out_data_o (out_data_o),
        .out_unit_o (out_unit),
        .out_seq_o  (out_seq_o),
        .out_last_o (out_last_o)
    );

    assign armed_o    = armed;
    assign out_unit_o = out_unit;

endmodule

// File: tb/dual_capture_pingpong_tb_top.sv
`timescale 1ns/1ps
module dual_capture_pingpong_tb_top;

    localparam int SW        = 10;
    localparam int NS        = 128;
    localparam int SQW       = 2;
    localparam int LW        = 3;
    localparam int CAP_DELAY = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trig = 1'b0;
    logic [1:0]      cap_start;
    logic [1:0]      cap_valid = 2'b00;
    logic [2*SW-1:0] cap_data = '0;
    logic [1:0]      cap_ready;
    logic [1:0]      busy;
    logic            armed;
    logic [LW-1:0]   lost;
    logic            out_valid;
    logic [SW-1:0]   out_data;
    logic            out_unit;
    logic [SQW-1:0]  out_seq;
    logic            out_last;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int exp_u [32];
    int exp_s [32];
    int n_exp = 0;
    int n_acc = 0;
    int rd = 0;
    int sidx = 0;

    always #2 clk = ~clk;

    dual_capture_pingpong #(
        .SAMPLE_W(SW), .SAMPLES(NS), .SEQ_W(SQW), .LOST_W(LW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig),
        .cap_start_o(cap_start), .cap_valid_i(cap_valid), .cap_data_i(cap_data),
        .cap_ready_o(cap_ready), .busy_o(busy), .armed_o(armed), .lost_cnt_o(lost),
        .out_valid_o(out_valid), .out_data_o(out_data), .out_unit_o(out_unit),
        .out_seq_o(out_seq), .out_last_o(out_last)
    );

    function automatic logic [SW-1:0] pat(input int u, input int i);
        return (u != 0 ? 10'h2AA : 10'h055) ^ SW'(i);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // capture-unit model: latency after start, then indexed samples advanced on grant
    initial begin
        bit act [2];
        int dly [2];
        int idx [2];
        bit acc [2];
        for (int u = 0; u < 2; u++) begin
            act[u] = 0; dly[u] = 0; idx[u] = 0; acc[u] = 0;
        end
        forever begin
            @(negedge clk);
            for (int u = 0; u < 2; u++) begin
                if (cap_start[u]) begin
                    chk(!act[u], "R2", "start reached a unit already capturing", 1, 0);
                    act[u] = 1; dly[u] = CAP_DELAY; idx[u] = 0; acc[u] = 0;
                end else if (act[u]) begin
                    if (dly[u] > 0) begin
                        dly[u]--;
                    end else begin
                        if (acc[u]) idx[u]++;
                        if (idx[u] == NS) begin
                            cap_valid[u] = 1'b0;
                            act[u] = 0;
                            acc[u] = 0;
                        end else begin
                            cap_valid[u] = 1'b1;
                            cap_data[u*SW +: SW] = pat(u, idx[u]);
                            acc[u] = cap_ready[u];
                        end
                    end
                end
            end
        end
    end

    // output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (rd >= n_exp) begin
                    chk(1'b0, "R7", "unexpected output sample", int'(out_unit), -1);
                end else begin
                    chk(out_unit == exp_u[rd][0], "R8", "unit tag", int'(out_unit), exp_u[rd]);
                    chk(int'(out_seq) == exp_s[rd], "R8", "sequence tag", int'(out_seq), exp_s[rd]);
                    chk(out_data == pat(exp_u[rd], sidx), "R8", "sample value", int'(out_data), int'(pat(exp_u[rd], sidx)));
                    chk(out_last == (sidx == NS - 1), "R9", "last flag", int'(out_last), int'(sidx == NS - 1));
                    sidx++;
                    if (sidx == NS) begin
                        sidx = 0;
                        rd++;
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic fire();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic expect_start(input int u, input string req);
        chk(cap_start == (2'b01 << u), req, "start pulse", int'(cap_start), 1 << u);
        chk(busy[u] == 1'b1, req, "busy set", int'(busy), 1 << u);
        chk(armed == ~u[0], req, "armed moved", int'(armed), 1 - u);
        exp_u[n_exp] = u;
        exp_s[n_exp] = n_acc % (1 << SQW);
        n_exp++;
        n_acc++;
    endtask

    task automatic wait_busy(input logic [1:0] v, input string req);
        int n = 0;
        while (busy !== v && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(busy === v, req, "busy pattern reached", int'(busy), int'(v));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 2'b00, "R1", "busy after reset", int'(busy), 0);
        chk(armed == 1'b0, "R1", "armed after reset", int'(armed), 0);
        chk(lost == '0, "R1", "lost after reset", int'(lost), 0);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(cap_ready == 2'b00, "R1", "ready after reset", int'(cap_ready), 0);
    endtask

    task automatic t_single();
        fire();
        expect_start(0, "R2");
        @(negedge clk);
        chk(cap_start == 2'b00, "R2", "start lasts one cycle", int'(cap_start), 0);
        repeat (100) @(negedge clk);
        chk(busy == 2'b01, "R6", "busy held mid-readout", int'(busy), 1);
        wait_busy(2'b00, "R6");
        chk(rd == 1, "R9", "records delivered", rd, 1);
        chk(out_last == 1'b1, "R6", "busy clears with last sample", int'(out_last), 1);
    endtask

    task automatic t_pair_and_lost();
        fire();
        expect_start(1, "R2");
        fire();
        expect_start(0, "R3");
        repeat (CAP_DELAY + 4) @(negedge clk);
        chk(cap_ready == 2'b10, "R7", "only head unit granted", int'(cap_ready), 2);
        chk(cap_valid[0] == 1'b1, "R7", "second unit offering", int'(cap_valid[0]), 1);
        fire();
        chk(cap_start == 2'b00, "R4", "no start when both busy", int'(cap_start), 0);
        chk(lost == 3'd1, "R4", "lost count step", int'(lost), 1);
        for (int k = 0; k < 8; k++) fire();
        chk(lost == 3'd7, "R5", "lost count saturates", int'(lost), 7);
        chk(busy == 2'b11, "R4", "both still busy", int'(busy), 3);
        wait_busy(2'b01, "R9");
        chk(rd == 2, "R9", "first record of pair done", rd, 2);
    endtask

    task automatic t_refill();
        // unit 1 free, unit 0 draining: trigger is taken by the free unit
        chk(armed == 1'b1, "R3", "armed is the free unit", int'(armed), 1);
        fire();
        expect_start(1, "R3");
        chk(lost == 3'd7, "R5", "lost unchanged on accept", int'(lost), 7);
        wait_busy(2'b00, "R9");
        chk(rd == 4, "R9", "records in trigger order", rd, 4);
    endtask

    task automatic t_wrap();
        fire();
        expect_start(0, "R8");
        wait_busy(2'b00, "R8");
        fire();
        expect_start(1, "R8");
        wait_busy(2'b00, "R8");
        chk(rd == 6, "R8", "records after sequence wrap", rd, 6);
        chk(rd == n_exp, "R9", "all expected records seen", rd, n_exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_pair_and_lost();
        t_refill();
        t_wrap();
        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule